// File: doc/BRIEF.md
# Clock Start-up and Fail-Safe Selector

This block decides which oscillator clocks the system. It chooses between a primary external oscillator and a divided-down internal oscillator. After power-on, once any power-up delay has ended, and again on every wake from sleep, it holds the CPU while it counts edges of the primary oscillator until that oscillator can be trusted. If two-speed start-up is enabled, the internal oscillator drives the system during that wait, and the CPU runs straight away. Once the primary source is running, a monitor compares it against a slow reference oscillator. If the primary clock stops, the monitor moves the system to the internal source and raises a sticky failure flag.

The block runs on one fast, free-running control clock `clk`. Each oscillator input is treated as a data level that is sampled through a two-flop synchroniser. The selected system clock is produced from a flop, so it cannot glitch. A switch between sources stops the old clock while it is low, holds the output low, and lets the new clock through only after two rising edges of the new clock. The internal source passes through a power-of-two postscaler whose setting takes effect at once and returns to its default on reset. The synchronised reference is also passed out as a clock for the watchdog, whichever main source is selected.

Top module: `clk_startup_failsafe`

## Requirements
- R1: In crystal mode (`xtal_mode_i`=1) the primary source counts as ready only after OST_CYCLES (1024) synchronised rising edges of `pri_osc_i`, counted from entry into the start-up state. With `xtal_mode_i`=0 it counts as ready in the first cycle of that state.
- R2: After reset, start-up begins once `pwrt_done_i` is high, or at once if `pwrt_en_i` is 0. A `wake_i` pulse during sleep restarts start-up.
- R3: `cpu_hold_o` is 1 while waiting for the power-up delay, during start-up when two-speed is off, and during sleep. It is 0 when running from either source.
- R4: With `two_speed_i`=1, the system clock comes from the internal source and `cpu_hold_o` is 0 during start-up. When the primary source is ready, the selection moves to the primary source.
- R5: While running from the primary source with `fscm_en_i`=1, if FAIL_REFS (4) rising edges of the reference pass with no primary rising edge, the selection moves to the internal source. It stays there until sleep and wake, or reset.
- R6: On a switch, the selection drops to none only while the old clock is low, and the output then stays low. The new source is connected on its second synchronised rising edge. The selection never goes directly from one source to the other.
- R7: The internal clock period is the internal oscillator period times 2^(7-`ircf_i`), where code 7 means divide by 1. A write with `ircf_we_i` takes effect at once. Reset restores code IRCF_RESET (6, divide by 2).
- R8: `fail_o` is set on a detected failure and stays set until a `fail_clr_i` pulse. If both happen in the same cycle, the set wins.
- R9: `on_primary_o` is 1 exactly while the primary source is connected to `sysclk_o`.
- R10: `wdt_clk_o` follows `lf_ref_i` after the two-flop synchroniser, whatever the main selection is.
- R11: In sleep no source is selected, and `sysclk_o` has no rising edge once the old clock has been stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock that samples all oscillators |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pri_osc_i | input | 1 | Raw primary oscillator level |
| int_osc_i | input | 1 | Raw internal oscillator level |
| lf_ref_i | input | 1 | Raw low-frequency reference level |
| pwrt_en_i | input | 1 | Power-up delay is in use |
| pwrt_done_i | input | 1 | Power-up delay has expired |
| xtal_mode_i | input | 1 | Primary is a crystal/resonator (run start-up count) |
| two_speed_i | input | 1 | Run from internal clock during start-up |
| fscm_en_i | input | 1 | Enable the primary clock monitor |
| sleep_i | input | 1 | Pulse: enter sleep |
| wake_i | input | 1 | Pulse: wake from sleep |
| fail_clr_i | input | 1 | Pulse: clear the failure flag |
| ircf_we_i | input | 1 | Load the postscaler code |
| ircf_i | input | 3 | Postscaler code (7 = divide by 1) |
| sysclk_o | output | 1 | Selected glitch-free system clock |
| cpu_hold_o | output | 1 | Execution hold |
| on_primary_o | output | 1 | System runs from the primary source |
| fail_o | output | 1 | Sticky primary-failure flag |
| wdt_clk_o | output | 1 | Synchronised reference for the watchdog |

## Verification
Every oscillator level reaches the logic two control cycles after it is sampled. `sysclk_o` lags the selected level by one more register. The state outputs `cpu_hold_o`, `on_primary_o` and `fail_o` change in the cycle right after the event that causes them. The bench steps a behavioural model on each rising edge and compares all five outputs 1 ns later, so those latencies are counted exactly. Longer effects, such as the 1024-edge count, failure detection and postscaled periods, are checked well inside or outside their windows. Edge counts allow a tolerance of one.

// File: rtl/csf_pkg.sv
package csf_pkg;
  parameter int SEL_W = 3;
  localparam int DIV_W = (1 << SEL_W) - 1;

  typedef enum logic [2:0] {
    ST_PWRT, ST_OST, ST_RUN_PRI, ST_RUN_INT, ST_SLEEP
  } seq_st_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_PRI, SRC_INT} src_e;

  // Postscaler tap: all-ones selects the undivided level
  function automatic logic postscale_tap(input logic [DIV_W-1:0] cnt,
                                         input logic lvl,
                                         input logic [SEL_W-1:0] sel);
    if (sel == {SEL_W{1'b1}}) return lvl;
    return cnt[(DIV_W-1) - int'(sel)];
  endfunction

  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/csf_osc_sync.sv
module csf_osc_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      end else begin
        s1 <= raw_i[g]; s2 <= s1; s3 <= s2;
      end
    end
    assign lvl_o[g]  = s2;
    assign rise_o[g] = csf_pkg::rise_of(s2, s3);
  end
endmodule

// File: rtl/csf_postscaler.sv
module csf_postscaler
  import csf_pkg::*;
#(
  parameter logic [SEL_W-1:0] IRCF_RESET = 3'd6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_lvl_i,
  input  logic             int_rise_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_lvl_o,
  output logic             div_rise_o
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] cnt_q;
  logic             lvl_d;

  assign div_lvl_o  = postscale_tap(cnt_q, int_lvl_i, sel_q);
  assign div_rise_o = rise_of(div_lvl_o, lvl_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= IRCF_RESET;
      cnt_q <= '0;
      lvl_d <= 1'b0;
    end else begin
      lvl_d <= div_lvl_o;
      if (int_rise_i) cnt_q <= cnt_q + 1'b1;
      if (we_i) sel_q <= sel_i;
    end
  end
endmodule

// File: rtl/csf_startup_seq.sv
module csf_startup_seq
  import csf_pkg::*;
#(
  parameter int OST_CYCLES = 1024,
  localparam int OST_W = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwrt_en_i,
  input  logic    pwrt_done_i,
  input  logic    xtal_i,
  input  logic    two_speed_i,
  input  logic    sleep_i,
  input  logic    wake_i,
  input  logic    pri_rise_i,
  input  logic    fail_evt_i,
  output seq_st_e st_o,
  output src_e    want_o,
  output logic    hold_o,
  output logic    ost_done_o
);
  seq_st_e          st_q;
  logic [OST_W-1:0] ost_q;

  assign st_o = st_q;
  assign ost_done_o = (st_q == ST_OST) &&
                      (!xtal_i || (pri_rise_i && ost_q == OST_W'(OST_CYCLES - 1)));

  always_comb begin
    hold_o = 1'b0;
    want_o = SRC_NONE;
    unique case (st_q)
      ST_PWRT: begin
        hold_o = 1'b1;
        want_o = two_speed_i ? SRC_INT : SRC_NONE;
      end
      ST_OST: begin
        hold_o = !two_speed_i;
        want_o = two_speed_i ? SRC_INT : SRC_NONE;
      end
      ST_RUN_PRI: want_o = SRC_PRI;
      ST_RUN_INT: want_o = SRC_INT;
      ST_SLEEP:   hold_o = 1'b1;
      default: begin
        hold_o = 1'b1;
        want_o = SRC_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PWRT;
      ost_q <= '0;
    end else begin
      if (st_q != ST_OST) ost_q <= '0;
      else if (xtal_i && pri_rise_i) ost_q <= ost_q + 1'b1;
      unique case (st_q)
        ST_PWRT:    if (!pwrt_en_i || pwrt_done_i) st_q <= ST_OST;
        ST_OST:     if (ost_done_o) st_q <= ST_RUN_PRI;
        ST_RUN_PRI: if (fail_evt_i) st_q <= ST_RUN_INT;
                    else if (sleep_i) st_q <= ST_SLEEP;
        ST_RUN_INT: if (sleep_i) st_q <= ST_SLEEP;
        ST_SLEEP:   if (wake_i) st_q <= ST_OST;
        default:    st_q <= ST_PWRT;
      endcase
    end
  end
endmodule

// File: rtl/csf_fail_monitor.sv
module csf_fail_monitor #(
  parameter int FAIL_REFS = 4,
  localparam int MON_W = $clog2(FAIL_REFS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pri_rise_i,
  input  logic ref_rise_i,
  input  logic clr_i,
  output logic fail_evt_o,
  output logic fail_o
);
  logic [MON_W-1:0] cnt_q;
  logic             flag_q;

  assign fail_evt_o = en_i && ref_rise_i && !pri_rise_i &&
                      (cnt_q == MON_W'(FAIL_REFS - 1));
  assign fail_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!en_i || pri_rise_i) cnt_q <= '0;
      else if (ref_rise_i)     cnt_q <= cnt_q + 1'b1;
      if (fail_evt_o)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/csf_clk_switch.sv
module csf_clk_switch
  import csf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e want_i,
  input  logic pri_lvl_i,
  input  logic pri_rise_i,
  input  logic int_lvl_i,
  input  logic int_rise_i,
  output src_e sel_o,
  output logic sysclk_o
);
  src_e sel_q, tgt_q;
  logic edge_seen_q;
  logic sys_q;
  logic cur_lvl, want_rise;

  always_comb begin
    unique case (sel_q)
      SRC_PRI: cur_lvl = pri_lvl_i;
      SRC_INT: cur_lvl = int_lvl_i;
      default: cur_lvl = 1'b0;
    endcase
    unique case (want_i)
      SRC_PRI: want_rise = pri_rise_i;
      SRC_INT: want_rise = int_rise_i;
      default: want_rise = 1'b0;
    endcase
  end

  assign sel_o    = sel_q;
  assign sysclk_o = sys_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= SRC_NONE;
      tgt_q       <= SRC_NONE;
      edge_seen_q <= 1'b0;
      sys_q       <= 1'b0;
    end else begin
      tgt_q <= want_i;
      sys_q <= cur_lvl;
      if (sel_q != SRC_NONE) begin
        edge_seen_q <= 1'b0;
        if (want_i != sel_q && !cur_lvl) sel_q <= SRC_NONE;
      end else if (want_i != tgt_q || want_i == SRC_NONE) begin
        edge_seen_q <= 1'b0;
      end else if (want_rise) begin
        if (edge_seen_q) begin
          sel_q       <= want_i;
          edge_seen_q <= 1'b0;
        end else begin
          edge_seen_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_startup_failsafe.sv
module clk_startup_failsafe
  import csf_pkg::*;
#(
  parameter int                OST_CYCLES = 1024,
  parameter int                FAIL_REFS  = 4,
  parameter logic [SEL_W-1:0]  IRCF_RESET = 3'd6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_osc_i,
  input  logic             int_osc_i,
  input  logic             lf_ref_i,
  input  logic             pwrt_en_i,
  input  logic             pwrt_done_i,
  input  logic             xtal_mode_i,
  input  logic             two_speed_i,
  input  logic             fscm_en_i,
  input  logic             sleep_i,
  input  logic             wake_i,
  input  logic             fail_clr_i,
  input  logic             ircf_we_i,
  input  logic [SEL_W-1:0] ircf_i,
  output logic             sysclk_o,
  output logic             cpu_hold_o,
  output logic             on_primary_o,
  output logic             fail_o,
  output logic             wdt_clk_o
);
  localparam int NOSC = 3;

  logic [NOSC-1:0] osc_lvl, osc_rise;
  logic pri_lvl, pri_rise, int_lvl, int_rise, ref_lvl, ref_rise;
  logic div_lvl, div_rise;
  logic fail_evt, mon_en, ost_done;
  seq_st_e st;
  src_e    want, sel;

  csf_osc_sync #(.N(NOSC)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({lf_ref_i, int_osc_i, pri_osc_i}),
    .lvl_o(osc_lvl), .rise_o(osc_rise)
  );
  assign {ref_lvl, int_lvl, pri_lvl}    = osc_lvl;
  assign {ref_rise, int_rise, pri_rise} = osc_rise;
  assign wdt_clk_o = ref_lvl;

  csf_postscaler #(.IRCF_RESET(IRCF_RESET)) u_post (
    .clk(clk), .rst_n(rst_n),
    .int_lvl_i(int_lvl), .int_rise_i(int_rise),
    .we_i(ircf_we_i), .sel_i(ircf_i),
    .div_lvl_o(div_lvl), .div_rise_o(div_rise)
  );

  csf_startup_seq #(.OST_CYCLES(OST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .pwrt_en_i(pwrt_en_i), .pwrt_done_i(pwrt_done_i),
    .xtal_i(xtal_mode_i), .two_speed_i(two_speed_i),
    .sleep_i(sleep_i), .wake_i(wake_i),
    .pri_rise_i(pri_rise), .fail_evt_i(fail_evt),
    .st_o(st), .want_o(want), .hold_o(cpu_hold_o), .ost_done_o(ost_done)
  );

  assign mon_en = fscm_en_i && (st == ST_RUN_PRI);

  csf_fail_monitor #(.FAIL_REFS(FAIL_REFS)) u_mon (
    .clk(clk), .rst_n(rst_n),
    .en_i(mon_en), .pri_rise_i(pri_rise), .ref_rise_i(ref_rise),
    .clr_i(fail_clr_i), .fail_evt_o(fail_evt), .fail_o(fail_o)
  );

  csf_clk_switch u_sw (
    .clk(clk), .rst_n(rst_n), .want_i(want),
    .pri_lvl_i(pri_lvl), .pri_rise_i(pri_rise),
    .int_lvl_i(div_lvl), .int_rise_i(div_rise),
    .sel_o(sel), .sysclk_o(sysclk_o)
  );

  assign on_primary_o = (sel == SRC_PRI);
endmodule

// File: rtl/csf_checker.sv
module csf_checker
  import csf_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sysclk_o,
  input logic    cpu_hold_o,
  input logic    fail_o,
  input logic    fail_clr_i,
  input logic    fail_evt,
  input logic    ost_done,
  input seq_st_e st,
  input src_e    sel
);
  p_fail_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> fail_o);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !fail_clr_i) |=> fail_o);

  p_fail_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (st == ST_RUN_INT));

  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_NONE && $past(sel) != SRC_NONE) |-> !sysclk_o);

  p_no_direct_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SRC_NONE && $past(sel) != SRC_NONE) |-> (sel == $past(sel)));

  p_sleep_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP) |-> cpu_hold_o);

  p_ready_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ost_done |=> (st == ST_RUN_PRI));
endmodule

bind clk_startup_failsafe csf_checker i_csf_checker (
  .clk(clk), .rst_n(rst_n), .sysclk_o(sysclk_o), .cpu_hold_o(cpu_hold_o),
  .fail_o(fail_o), .fail_clr_i(fail_clr_i), .fail_evt(fail_evt),
  .ost_done(ost_done), .st(st), .sel(sel)
);

// File: tb/test_clk_startup_failsafe.sv
`timescale 1ns/1ps
module test_clk_startup_failsafe;
  localparam int OSTN = 1024;
  localparam int FREFS = 4;
  localparam int PRI_HALF = 4, INT_HALF = 3, REF_HALF = 20;

  logic clk = 0, rst_n = 0;
  logic pri_osc = 0, int_osc = 0, lf_ref = 0;
  logic pwrt_en = 1, pwrt_done = 0, xtal = 1, two_speed = 0, fscm = 1;
  logic sleep_p = 0, wake_p = 0, clr_p = 0, ircf_we = 0;
  logic [2:0] ircf_d = 0;
  logic sysclk, hold, onpri, fail, wdt;
  bit pri_run = 1;

  int n_chk = 0, n_bad = 0, cyc = 0, rises = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_startup_failsafe i_clk_startup_failsafe (
    .clk(clk), .rst_n(rst_n), .pri_osc_i(pri_osc), .int_osc_i(int_osc),
    .lf_ref_i(lf_ref), .pwrt_en_i(pwrt_en), .pwrt_done_i(pwrt_done),
    .xtal_mode_i(xtal), .two_speed_i(two_speed), .fscm_en_i(fscm),
    .sleep_i(sleep_p), .wake_i(wake_p), .fail_clr_i(clr_p),
    .ircf_we_i(ircf_we), .ircf_i(ircf_d), .sysclk_o(sysclk),
    .cpu_hold_o(hold), .on_primary_o(onpri), .fail_o(fail), .wdt_clk_o(wdt));

  // raw oscillators, changed away from the sampling edge
  int pc = 0, ic = 0, rc = 0;
  always @(negedge clk) begin
    pc++; ic++; rc++;
    if (pc >= PRI_HALF) begin pc = 0; pri_osc <= pri_run ? ~pri_osc : 1'b0; end
    if (!pri_run) pri_osc <= 1'b0;
    if (ic >= INT_HALF) begin ic = 0; int_osc <= ~int_osc; end
    if (rc >= REF_HALF) begin rc = 0; lf_ref <= ~lf_ref; end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_near(string req, int act, int exp);
    n_chk++;
    if (act < exp - 1 || act > exp + 1) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d+-1", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit hp[$], hi[$], hr[$];           // sampled history, newest at back
  int m_ircf, m_dcnt, m_st, m_ost, m_mon, m_sel, m_tgt, m_edge;
  bit m_divd, m_fail, m_sys;
  // states: 0 wait power-up, 1 start-up count, 2 primary, 3 internal, 4 sleep
  // sources: 0 none, 1 primary, 2 internal

  function automatic bit lvl_of(ref bit h[$]); return h[1]; endfunction
  function automatic bit rise_in(ref bit h[$]); return h[1] && !h[0]; endfunction

  task automatic model_reset();
    hp = '{0,0,0}; hi = '{0,0,0}; hr = '{0,0,0};
    m_ircf = 6; m_dcnt = 0; m_st = 0; m_ost = 0; m_mon = 0;
    m_sel = 0; m_tgt = 0; m_edge = 0; m_divd = 0; m_fail = 0; m_sys = 0;
  endtask

  task automatic model_step();
    // queue order: [0]=third stage, [1]=second stage, [2]=first stage
    bit pl = hp[1], pr = hp[1] && !hp[0];
    bit il = hi[1], ir = hi[1] && !hi[0];
    bit rr = hr[1] && !hr[0];
    bit dl, dr, fe, ready, curl, wr;
    int want, nst;
    dl = (m_ircf == 7) ? il : bit'((m_dcnt / (1 << (6 - m_ircf))) % 2);
    dr = dl && !m_divd;
    case (m_st)
      0, 1: want = two_speed ? 2 : 0;
      2: want = 1;
      3: want = 2;
      default: want = 0;
    endcase
    fe = fscm && m_st == 2 && rr && !pr && m_mon == FREFS - 1;
    ready = !xtal || (pr && m_ost == OSTN - 1);
    nst = m_st;
    if (m_st == 0 && (!pwrt_en || pwrt_done)) nst = 1;
    else if (m_st == 1 && ready) nst = 2;
    else if (m_st == 2 && fe) nst = 3;
    else if ((m_st == 2 || m_st == 3) && sleep_p) nst = 4;
    else if (m_st == 4 && wake_p) nst = 1;
    if (m_st != 1) m_ost = 0; else if (xtal && pr) m_ost++;
    if (!(fscm && m_st == 2) || pr) m_mon = 0; else if (rr) m_mon++;
    if (fe) m_fail = 1; else if (clr_p) m_fail = 0;
    curl = (m_sel == 1) ? pl : (m_sel == 2) ? dl : 0;
    wr = (want == 1) ? pr : (want == 2) ? dr : 0;
    m_sys = curl;
    if (m_sel != 0) begin
      m_edge = 0;
      if (want != m_sel && !curl) m_sel = 0;
    end else if (want != m_tgt || want == 0) m_edge = 0;
    else if (wr) begin
      if (m_edge == 1) begin m_sel = want; m_edge = 0; end
      else m_edge = 1;
    end
    m_tgt = want;
    if (ir) m_dcnt = (m_dcnt + 1) % 128;
    m_divd = dl;
    if (ircf_we) m_ircf = int'(ircf_d);
    m_st = nst;
    void'(hp.pop_front()); hp.push_back(pri_osc);
    void'(hi.pop_front()); hi.push_back(int_osc);
    void'(hr.pop_front()); hr.push_back(lf_ref);
  endtask

  bit prev_sys = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset(); else model_step();
    #1;
    if (rst_n && !done) begin
      chk("R3 hold", int'(hold), int'(m_st == 0 || m_st == 4 || (m_st == 1 && !two_speed)));
      chk("R6 sysclk", int'(sysclk), int'(m_sys));
      chk("R9 on_primary", int'(onpri), int'(m_sel == 1));
      chk("R8 fail", int'(fail), int'(m_fail));
      chk("R10 wdt clock", int'(wdt), int'(hr[1]));
    end
    if (sysclk && !prev_sys) rises++;
    prev_sys = sysclk;
  end

  task automatic wait_cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(ref logic s); @(negedge clk); s = 1; @(negedge clk); s = 0; endtask
  task automatic measure(int n, output int r); rises = 0; wait_cyc(n); r = rises; endtask
  task automatic do_reset(); @(negedge clk); rst_n = 0; wait_cyc(3); rst_n = 1; endtask

  initial begin
    int r;
    // A: power-up with delay timer, crystal, no two-speed
    wait_cyc(3); rst_n = 1; wait_cyc(2);
    chk("R3 reset hold", int'(hold), 1);
    chk("R9 reset on_primary", int'(onpri), 0);
    chk("R8 reset fail", int'(fail), 0);
    wait_cyc(40);
    chk("R2 waits for power-up timer", int'(hold), 1);
    pwrt_done = 1;
    measure(4000, r);
    chk("R3 no clock while held", r, 0);
    wait_cyc(4000);
    chk("R1 still counting at 8000", int'(hold), 1);
    wait_cyc(400);
    chk("R1 released after count", int'(hold), 0);
    chk("R9 primary connected", int'(onpri), 1);
    measure(800, r);
    chk_near("R9 primary period", r, 100);
    // B: primary stops -> fail-safe
    pri_run = 0;
    wait_cyc(400);
    chk("R8 fail flag set", int'(fail), 1);
    chk("R5 moved to internal", int'(onpri), 0);
    chk("R5 still running", int'(hold), 0);
    measure(1200, r);
    chk_near("R7 default divide by 2", r, 100);
    // C: clear flag, selection stays internal
    pulse(clr_p); wait_cyc(3);
    chk("R8 cleared", int'(fail), 0);
    pri_run = 1; wait_cyc(200);
    chk("R5 stays internal", int'(onpri), 0);
    // D: postscaler writes
    @(negedge clk); ircf_d = 3'd7; ircf_we = 1; @(negedge clk); ircf_we = 0;
    wait_cyc(50); measure(1200, r);
    chk_near("R7 divide by 1", r, 200);
    @(negedge clk); ircf_d = 3'd5; ircf_we = 1; @(negedge clk); ircf_we = 0;
    wait_cyc(100); measure(1200, r);
    chk_near("R7 divide by 4", r, 50);
    // E: sleep
    pulse(sleep_p); wait_cyc(50);
    chk("R11 sleep holds", int'(hold), 1);
    measure(500, r);
    chk("R11 no clock in sleep", r, 0);
    // F: wake with two-speed
    two_speed = 1;
    pulse(wake_p); wait_cyc(100);
    chk("R4 two-speed releases hold", int'(hold), 0);
    chk("R4 internal during start-up", int'(onpri), 0);
    measure(1200, r);
    chk_near("R7 setting kept across sleep", r, 50);
    wait_cyc(7300);
    chk("R2 wake restarts start-up, R4 handover", int'(onpri), 1);
    // G: reset restores postscaler default
    pwrt_en = 0; pri_run = 0; do_reset(); wait_cyc(100);
    measure(1200, r);
    chk_near("R7 default after reset", r, 100);
    chk("R4 hold low in two-speed", int'(hold), 0);
    // H: external-clock mode skips the count
    xtal = 0; two_speed = 0; pri_run = 1; do_reset(); wait_cyc(60);
    chk("R1 no count in external mode", int'(onpri), 1);
    chk("R3 running", int'(hold), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule